// File: doc/BRIEF.md
# Dirty Line Eviction Drain Buffer

This block parks one evicted dirty cache line, with its physical line address, so that the cache controller can fetch the replacement line first. The controller hands over the whole line in a single strobe: four 32-bit longwords, line address bits 31:4, and the longword offset where the drain is to begin. The buffer then waits for the controller's fill-busy flag to drop. Only after that does it write the line to memory as four single-longword bus writes.

The drain order is wrap-around. It starts at the latched offset and steps up through the line, wrapping from the last longword back to the first. Each write holds its address and data until the memory side samples ready. The cache keeps serving accesses during the drain, because nothing in this block stalls the cache pipeline. While the buffer holds a line it reports full, and the controller must hold off the next eviction until full drops.

Top module: `wbb_line_buffer`

## Requirements
- R1: When `full_o` is low, a high `load_i` at a rising clock edge captures `line_data_i`, `line_addr_i` and `start_off_i`, and `full_o` is high from the following cycle.
- R2: During a write, `bus_addr_o` equals {3'b000, stored address bits 24:0, 2-bit longword index, 2'b00}, so its top three bits are always zero. `bus_data_o` is longword k of the stored line, where longword k sits in bits [32k+31:32k] of `line_data_i`.
- R3: No write is issued while `fill_busy_i` is high. After a load, the first edge that samples `fill_busy_i` low starts the drain, and `bus_we_o` is high from the next cycle.
- R4: The four writes use longword indices s, s+1, s+2, s+3 modulo 4, where s is the latched start offset.
- R5: While `bus_we_o` is high and `bus_ready_i` is low, `bus_addr_o`, `bus_data_o` and `bus_we_o` hold their values. A beat advances only at an edge where `bus_ready_i` is high.
- R6: `load_i` has no effect while `full_o` is high, including in the cycle in which the fourth beat is accepted. The line already held drains unchanged, and no extra drain follows.
- R7: At the edge that accepts the fourth beat, `full_o` and `bus_we_o` both drop, so both are low in the following cycle.
- R8: Changes to `start_off_i`, `line_addr_i` and `line_data_i` after the load edge do not change the drained addresses, data or order.
- R9: While `rst_ni` is low, `full_o` and `bus_we_o` are low. Asserting reset during a drain discards the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Eviction strobe from the cache controller |
| line_addr_i | input | 28 | Physical line address, bits 31:4 |
| line_data_i | input | 128 | Evicted line, longword k in bits [32k+31:32k] |
| start_off_i | input | 2 | Longword index at which the drain begins |
| fill_busy_i | input | 1 | High while the replacement line is being fetched |
| bus_ready_i | input | 1 | Memory accepts the current write |
| full_o | output | 1 | Buffer holds a line; new evictions must wait |
| bus_addr_o | output | 32 | Byte address of the current write |
| bus_data_o | output | 32 | Data of the current write |
| bus_we_o | output | 1 | Write request |

## Verification
Two events can land in the same cycle: a new eviction strobe, and acceptance of the buffer's final beat. The bench raises `load_i` with different data exactly in the cycle where the fourth beat is accepted. It then checks that `full_o` falls and stays low and that no further write appears, which shows the strobe was refused. A second overlap is a load whose fill flag is already low in the same cycle. The bench checks that the drain then begins two cycles after the load strobe, and that every beat's address, data and wrap order match values computed from the table entry.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  typedef enum logic [1:0] {
    WB_IDLE  = 2'd0,
    WB_HOLD  = 2'd1,
    WB_DRAIN = 2'd2
  } wb_state_e;
endpackage

// File: rtl/wbb_store.sv
module wbb_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BEATS  = 4,
  parameter int unsigned LA_W   = 28,
  parameter int unsigned OFF_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_i,
  input  logic [LA_W-1:0]         line_addr_i,
  input  logic [DATA_W*BEATS-1:0] line_data_i,
  input  logic [OFF_W-1:0]        start_off_i,
  output logic [LA_W-1:0]         line_addr_o,
  output logic [DATA_W*BEATS-1:0] line_data_o,
  output logic [OFF_W-1:0]        start_off_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_addr_o <= '0;
      line_data_o <= '0;
      start_off_o <= '0;
    end else if (cap_i) begin
      line_addr_o <= line_addr_i;
      line_data_o <= line_data_i;
      start_off_o <= start_off_i;
    end
  end
endmodule

// File: rtl/wbb_seq.sv
module wbb_seq
  import wbb_pkg::*;
#(
  parameter int unsigned BEATS = 4,
  parameter int unsigned OFF_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             fill_busy_i,
  input  logic             bus_ready_i,
  input  logic [OFF_W-1:0] start_q_i,
  output logic             cap_o,
  output logic             full_o,
  output logic             we_o,
  output logic [OFF_W-1:0] idx_o
);
  localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(BEATS - 1);
  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(BEATS - 1);

  wb_state_e        state_q, state_d;
  logic [OFF_W-1:0] cnt_q, cnt_d;
  logic [OFF_W-1:0] idx_q, idx_d;
  logic             beat_ok;

  assign beat_ok = (state_q == WB_DRAIN) && bus_ready_i;
  assign cap_o   = load_i && (state_q == WB_IDLE);
  assign full_o  = (state_q != WB_IDLE);
  assign we_o    = (state_q == WB_DRAIN);
  assign idx_o   = idx_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    unique case (state_q)
      WB_IDLE: if (load_i) state_d = WB_HOLD;
      WB_HOLD: begin
        // the fill has priority; drain only once it is done
        if (!fill_busy_i) begin
          state_d = WB_DRAIN;
          cnt_d   = '0;
          idx_d   = start_q_i;
        end
      end
      WB_DRAIN: begin
        if (beat_ok) begin
          if (cnt_q == LAST_CNT) begin
            state_d = WB_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
            idx_d = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
          end
        end
      end
      default: state_d = WB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WB_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/wbb_beat_mux.sv
module wbb_beat_mux #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BEATS    = 4,
  parameter int unsigned LA_W     = 28,
  parameter int unsigned OFF_W    = 2,
  parameter int unsigned BYTE_OFF = 2,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ZERO_TOP = 3
) (
  input  logic [LA_W-1:0]         line_addr_i,
  input  logic [DATA_W*BEATS-1:0] line_data_i,
  input  logic [OFF_W-1:0]        idx_i,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [DATA_W-1:0]       data_o
);
  logic [DATA_W-1:0] words [BEATS];
  logic [ADDR_W-1:0] raw_addr;

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    assign words[g] = line_data_i[g*DATA_W +: DATA_W];
  end

  assign data_o   = words[idx_i];
  assign raw_addr = {line_addr_i, idx_i, {BYTE_OFF{1'b0}}};

  if (ZERO_TOP > 0) begin : g_mask
    assign addr_o = {{ZERO_TOP{1'b0}}, raw_addr[ADDR_W-ZERO_TOP-1:0]};
  end else begin : g_nomask
    assign addr_o = raw_addr;
  end
endmodule

// File: rtl/wbb_line_buffer.sv
module wbb_line_buffer #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BEATS    = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ZERO_TOP = 3,
  localparam int unsigned OFF_W    = $clog2(BEATS),
  localparam int unsigned BYTE_OFF = $clog2(DATA_W / 8),
  localparam int unsigned LA_W     = ADDR_W - OFF_W - BYTE_OFF,
  localparam int unsigned LINE_W   = DATA_W * BEATS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LA_W-1:0]   line_addr_i,
  input  logic [LINE_W-1:0] line_data_i,
  input  logic [OFF_W-1:0]  start_off_i,
  input  logic              fill_busy_i,
  input  logic              bus_ready_i,
  output logic              full_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_we_o
);
  logic              cap;
  logic [LA_W-1:0]   la_q;
  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  start_q;
  logic [OFF_W-1:0]  idx;

  wbb_store #(.DATA_W(DATA_W), .BEATS(BEATS), .LA_W(LA_W), .OFF_W(OFF_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .line_addr_i (line_addr_i),
    .line_data_i (line_data_i),
    .start_off_i (start_off_i),
    .line_addr_o (la_q),
    .line_data_o (line_q),
    .start_off_o (start_q)
  );

  wbb_seq #(.BEATS(BEATS), .OFF_W(OFF_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .fill_busy_i (fill_busy_i),
    .bus_ready_i (bus_ready_i),
    .start_q_i   (start_q),
    .cap_o       (cap),
    .full_o      (full_o),
    .we_o        (bus_we_o),
    .idx_o       (idx)
  );

  wbb_beat_mux #(
    .DATA_W(DATA_W), .BEATS(BEATS), .LA_W(LA_W), .OFF_W(OFF_W),
    .BYTE_OFF(BYTE_OFF), .ADDR_W(ADDR_W), .ZERO_TOP(ZERO_TOP)
  ) u_mux (
    .line_addr_i (la_q),
    .line_data_i (line_q),
    .idx_i       (idx),
    .addr_o      (bus_addr_o),
    .data_o      (bus_data_o)
  );
endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFF_W    = 2,
  parameter int unsigned BYTE_OFF = 2,
  parameter int unsigned ZERO_TOP = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              fill_busy_i,
  input logic              bus_ready_i,
  input logic              full_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_we_o
);
  a_r1_load_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !full_o |=> full_o);

  a_r2_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> bus_addr_o[ADDR_W-1 -: ZERO_TOP] == '0);

  a_r3_wait_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_we_o) |-> !$past(fill_busy_i));

  a_r4_wrap_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o && bus_ready_i |=> !bus_we_o ||
      bus_addr_o[BYTE_OFF +: OFF_W] == OFF_W'($past(bus_addr_o[BYTE_OFF +: OFF_W]) + 1'b1));

  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o && !bus_ready_i |=> bus_we_o && $stable(bus_addr_o) && $stable(bus_data_o));

  a_r6_we_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> full_o);

  a_r7_clear_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(bus_we_o && bus_ready_i));
endmodule

bind wbb_line_buffer wbb_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
  .BYTE_OFF(BYTE_OFF), .ZERO_TOP(ZERO_TOP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .fill_busy_i (fill_busy_i),
  .bus_ready_i (bus_ready_i),
  .full_o      (full_o),
  .bus_addr_o  (bus_addr_o),
  .bus_data_o  (bus_data_o),
  .bus_we_o    (bus_we_o)
);

// File: tb/wbb_line_buffer_test.sv
module wbb_line_buffer_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [27:0] la;
    logic [31:0] seed;
    logic [1:0]  st;
    logic [2:0]  fill;
    logic [1:0]  stall;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{28'h0000001, 32'h1000_0000, 2'd0, 3'd0, 2'd0},
    '{28'h0ABCDE2, 32'h2345_6789, 2'd1, 3'd2, 2'd1},
    '{28'hFFFFFFF, 32'hDEAD_BEEF, 2'd2, 3'd1, 2'd0},
    '{28'hE123456, 32'h0F0F_0F0F, 2'd3, 3'd4, 2'd2},
    '{28'h8000000, 32'hA5A5_5A5A, 2'd1, 3'd0, 2'd3},
    '{28'h1234567, 32'h7777_0001, 2'd3, 3'd3, 2'd1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic [27:0]  la_in = '0;
  logic [127:0] line_in = '0;
  logic [1:0]   st_in = '0;
  logic         fbusy = 1'b0;
  logic         rdy = 1'b0;
  logic         full;
  logic [31:0]  baddr;
  logic [31:0]  bdata;
  logic         bwe;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  wbb_line_buffer uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .line_addr_i(la_in),
    .line_data_i(line_in), .start_off_i(st_in), .fill_busy_i(fbusy),
    .bus_ready_i(rdy), .full_o(full), .bus_addr_o(baddr),
    .bus_data_o(bdata), .bus_we_o(bwe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [31:0] seed, input int k);
    return seed + 32'(k) * 32'h1111_1111;
  endfunction

  function automatic logic [127:0] line_of(input logic [31:0] seed);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = word_of(seed, k);
    return l;
  endfunction

  function automatic logic [31:0] addr_of(input logic [27:0] la, input logic [1:0] idx);
    return {3'b000, la[24:0], idx, 2'b00};
  endfunction

  // called at a negedge with full low
  task automatic run_line(input logic [27:0] la, input logic [31:0] seed, input logic [1:0] st,
                          input int fill, input int stall, input bit load_at_last);
    load = 1'b1; la_in = la; line_in = line_of(seed); st_in = st; fbusy = (fill > 0);
    @(negedge clk);
    load = 1'b0;
    // R8: scramble inputs after the load edge
    la_in = ~la; line_in = ~line_of(seed); st_in = st + 2'd1;
    chk(full === 1'b1, "R1 full after load", 32'(full), 32'd1);
    chk(bwe === 1'b0, "R3 no write right after load", 32'(bwe), 32'd0);
    for (int i = 0; i < fill; i++) begin
      chk(bwe === 1'b0, "R3 no write while fill busy", 32'(bwe), 32'd0);
      if (i == 1) begin
        // R6: load while full is ignored
        load = 1'b1; line_in = line_of(32'h5555_AAAA);
      end
      @(negedge clk);
      load = 1'b0;
    end
    fbusy = 1'b0;
    @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      logic [1:0] idx;
      idx = st + 2'(b);
      for (int s = 0; s < stall; s++) begin
        rdy = 1'b0;
        chk(bwe === 1'b1, "R5 request held", 32'(bwe), 32'd1);
        chk(baddr === addr_of(la, idx), "R5 addr held", baddr, addr_of(la, idx));
        chk(bdata === word_of(seed, idx), "R5 data held", bdata, word_of(seed, idx));
        @(negedge clk);
      end
      rdy = 1'b1;
      chk(bwe === 1'b1, "R3 write issued", 32'(bwe), 32'd1);
      chk(baddr === addr_of(la, idx), "R2 R4 R8 beat address", baddr, addr_of(la, idx));
      chk(bdata === word_of(seed, idx), "R2 R8 beat data", bdata, word_of(seed, idx));
      chk(full === 1'b1, "R7 full during drain", 32'(full), 32'd1);
      if (b == 3 && load_at_last) begin
        load = 1'b1; la_in = 28'h0000777; line_in = line_of(32'h0BAD_0BAD); st_in = 2'd0;
      end
      @(negedge clk);
      load = 1'b0;
    end
    rdy = 1'b0;
    chk(full === 1'b0, "R7 full clears after fourth beat", 32'(full), 32'd0);
    chk(bwe === 1'b0, "R7 write drops after fourth beat", 32'(bwe), 32'd0);
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    #1;
    chk(full === 1'b0, "R9 reset full", 32'(full), 32'd0);
    chk(bwe === 1'b0, "R9 reset write", 32'(bwe), 32'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[v]) begin
      run_line(VECS[v].la, VECS[v].seed, VECS[v].st, int'(VECS[v].fill), int'(VECS[v].stall), 1'b0);
      @(negedge clk);
    end

    // R6: load in the final-accept cycle is refused
    run_line(28'h0345678, 32'h3141_5926, 2'd2, 0, 0, 1'b1);
    @(negedge clk);
    chk(full === 1'b0, "R6 late load refused", 32'(full), 32'd0);
    chk(bwe === 1'b0, "R6 no extra drain", 32'(bwe), 32'd0);
    @(negedge clk);
    chk(bwe === 1'b0, "R6 still no extra drain", 32'(bwe), 32'd0);

    // R1: back-to-back line accepted right after full clears
    run_line(28'h0000042, 32'h2718_2818, 2'd3, 0, 0, 1'b0);
    run_line(28'h0000043, 32'h1414_2135, 2'd1, 1, 0, 1'b0);

    // R9: reset mid-drain discards the line
    load = 1'b1; la_in = 28'h0000099; line_in = line_of(32'h9999_0000); st_in = 2'd0;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    chk(bwe === 1'b1, "R9 drain started before reset", 32'(bwe), 32'd1);
    rst_n = 1'b0;
    #1;
    chk(full === 1'b0, "R9 reset clears full", 32'(full), 32'd0);
    chk(bwe === 1'b0, "R9 reset clears write", 32'(bwe), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(full === 1'b0, "R9 stays empty after reset", 32'(full), 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule